// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a synchronous SRAM in which address, control and data are all registered. One command is accepted on each clock edge, and the data slot that belongs to it falls exactly two edges later, whether it is a read or a write. Because reads and writes share the same latency, a read can follow a write (or the reverse) on consecutive cycles without an idle slot on the data bus.

An internal burst counter lets one loaded address serve a run of accesses. Each advance cycle produces the next address in either linear or interleaved order. Four active-low lane strobes select which 9-bit lanes of a 36-bit word a write updates. A clock enable freezes the whole pipeline. An asynchronous output enable can remove the read drivers at any moment. A sleep input keeps new work from starting.

The data bus is split into an input path, an output path and a drive-enable, which together stand for one bidirectional pad bus. The array depth comes from the address-width parameter.

Top module: `turnless_sram`

## Requirements
- R1: A command sampled at edge k that is a read drives its word on data_o, with data_oe_o high, from edge k+2. A write command sampled at edge k stores data_i as sampled at edge k+2.
- R2: Reads and writes can be issued on consecutive enabled edges in any mix without idle cycles, and each one completes with the R1 timing.
- R3: While clk_en_ni is 1, every input is ignored and all internal state, including the output register and the array, keeps its value.
- R4: A load cycle (adv_i=0) starts a command only when ce0_ni=0, ce1_i=1, ce2_ni=0 and sleep_i=0. Any other load cycle is a deselect and ends the current burst. An advance cycle with no burst active is also a deselect.
- R5: A deselect does not cancel commands already in the pipeline. data_oe_o falls after edge k+2 when the command at edge k was a deselect or a write.
- R6: An advance cycle (adv_i=1) during an active burst accesses the next beat n, where n counts 1,2,3,0,... after the load. Address bits [ADDR_W-1:2] stay at the loaded value. Bits [1:0] become (base+n) mod 4 when burst_lin_i was 1 at load, or base XOR n when it was 0.
- R7: byte_we_ni[i]=0 lets a write update lane i, which is data bits [9i+8:9i]. The strobes are sampled together with the command on both load and advance cycles.
- R8: An advance cycle keeps the read/write direction of its load cycle, and rd_wr_i is ignored on advance cycles. rd_wr_i=1 means read and 0 means write.
- R9: oe_ni=1 forces data_oe_o low at once, with no clock. data_o is zero whenever data_oe_o is low.
- R10: sleep_i=1 turns the cycle into a deselect and ends any burst. Pending commands still complete, and the array contents are kept.
- R11: rst_ni=0 asynchronously empties the pipeline and ends any burst, so data_oe_o is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_ni | input | 1 | Clock enable, active low; 1 stalls the block |
| ce0_ni | input | 1 | Chip enable, active low |
| ce1_i | input | 1 | Chip enable, active high |
| ce2_ni | input | 1 | Chip enable, active low |
| rd_wr_i | input | 1 | 1 read, 0 write (load cycles only) |
| adv_i | input | 1 | 0 load new address, 1 advance burst |
| burst_lin_i | input | 1 | 1 linear, 0 interleaved order (sampled at load) |
| byte_we_ni | input | LANES | Lane write strobes, active low |
| addr_i | input | ADDR_W | Word address |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Blocks new commands |
| data_i | input | LANES*LANE_W | Write data from the pad bus |
| data_o | output | LANES*LANE_W | Read data to the pad bus |
| data_oe_o | output | 1 | Pad bus drive enable |

## Verification
The bench targets write-then-read and read-then-write pairs to the same address. A design with unequal read and write latency would return stale words there or collide on the bus. Bursts run past four beats in both orders from every low-address start, and rd_wr_i is toggled during advance cycles. A wrong counter or a direction taken from the advance cycle would hit the wrong word. Deselects, sleep and stalls are placed between issued commands: cancelling pending work would lose read data, and leaking through a stall would move the data slot. oe_ni is toggled between clock edges to catch a registered output enable.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic {ORD_INTLV = 1'b0, ORD_LINEAR = 1'b1} burst_ord_e;

  localparam int unsigned BURST_BEATS = 4;
  localparam int unsigned BEAT_W      = $clog2(BURST_BEATS);

  function automatic logic [BEAT_W-1:0] beat_lo(logic [BEAT_W-1:0] base,
                                                logic [BEAT_W-1:0] beat,
                                                burst_ord_e        ord);
    return (ord == ORD_LINEAR) ? base + beat : base ^ beat;
  endfunction
endpackage

// File: rtl/sram_burst_ctl.sv
module sram_burst_ctl
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sel_ok_i,
  input  logic              sleep_i,
  input  logic              adv_i,
  input  logic              rd_wr_i,
  input  logic              burst_lin_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cmd_vld_o,
  output logic              cmd_wr_o,
  output logic [ADDR_W-1:0] cmd_addr_o
);
  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  logic              act_q, wr_q;
  burst_ord_e        ord_q;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q, beat_nx;
  logic              start_ok;

  assign start_ok = sel_ok_i && !sleep_i;
  assign beat_nx  = beat_q + 1'b1;

  always_comb begin
    if (!adv_i) begin
      cmd_vld_o  = start_ok;
      cmd_wr_o   = !rd_wr_i;
      cmd_addr_o = addr_i;
    end else begin
      cmd_vld_o  = act_q && !sleep_i;
      cmd_wr_o   = wr_q;
      cmd_addr_o = {base_q[ADDR_W-1 -: HI_W], beat_lo(base_q[BEAT_W-1:0], beat_nx, ord_q)};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      ord_q  <= ORD_INTLV;
      base_q <= '0;
      beat_q <= '0;
    end else if (en_i) begin
      if (!adv_i) begin
        act_q  <= start_ok;
        wr_q   <= !rd_wr_i;
        ord_q  <= burst_ord_e'(burst_lin_i);
        base_q <= addr_i;
        beat_q <= '0;
      end else if (sleep_i) begin
        act_q <= 1'b0;
      end else if (act_q) begin
        beat_q <= beat_nx;
      end
    end
  end

  // R6
  burst_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && adv_i && act_q && !sleep_i) |=> (act_q && beat_q == $past(beat_q) + 1'b1));

  // R4
  no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !adv_i && !(sel_ok_i && !sleep_i)) |=> !act_q);

  // R10
  sleep_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sleep_i) |=> !act_q);
endmodule

// File: rtl/sram_cmd_pipe.sv
module sram_cmd_pipe #(
  parameter int unsigned WIDTH  = 12,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else if (en_i) begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

  // R3
  pipe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic                    re_i,
  input  logic [LANES-1:0]        be_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (we_i && !be_ni[l]) mem_q[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rd_q <= '0;
      else if (re_i) rd_q <= mem_q[addr_i];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/turnless_sram.sv
module turnless_sram #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clk_en_ni,
  input  logic                    ce0_ni,
  input  logic                    ce1_i,
  input  logic                    ce2_ni,
  input  logic                    rd_wr_i,
  input  logic                    adv_i,
  input  logic                    burst_lin_i,
  input  logic [LANES-1:0]        byte_we_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    oe_ni,
  input  logic                    sleep_i,
  input  logic [LANES*LANE_W-1:0] data_i,
  output logic [LANES*LANE_W-1:0] data_o,
  output logic                    data_oe_o
);
  localparam int unsigned DATA_W  = LANES * LANE_W;
  localparam int unsigned PAY_W   = 2 + LANES + ADDR_W;
  localparam int unsigned LATENCY = 2;

  logic              en, sel_ok;
  logic              c_vld, c_wr;
  logic [ADDR_W-1:0] c_addr;
  logic [PAY_W-1:0]  c_pay, s_pay;
  logic              s_vld, s_wr;
  logic [LANES-1:0]  s_be_n;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] rd_data;
  logic              rd_valid_q;

  assign en     = !clk_en_ni;
  assign sel_ok = !ce0_ni && ce1_i && !ce2_ni;

  sram_burst_ctl #(.ADDR_W(ADDR_W)) u_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .sel_ok_i   (sel_ok),
    .sleep_i    (sleep_i),
    .adv_i      (adv_i),
    .rd_wr_i    (rd_wr_i),
    .burst_lin_i(burst_lin_i),
    .addr_i     (addr_i),
    .cmd_vld_o  (c_vld),
    .cmd_wr_o   (c_wr),
    .cmd_addr_o (c_addr)
  );

  assign c_pay = {c_vld, c_wr, byte_we_ni, c_addr};

  sram_cmd_pipe #(.WIDTH(PAY_W), .STAGES(LATENCY)) u_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en),
    .d_i   (c_pay),
    .q_o   (s_pay)
  );

  assign {s_vld, s_wr, s_be_n, s_addr} = s_pay;

  sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (en && s_vld && s_wr),
    .re_i   (en && s_vld && !s_wr),
    .be_ni  (s_be_n),
    .addr_i (s_addr),
    .wdata_i(data_i),
    .rdata_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rd_valid_q <= 1'b0;
    else if (en)  rd_valid_q <= s_vld && !s_wr;
  end

  // output enable is the only unclocked path
  assign data_oe_o = rd_valid_q && !oe_ni;
  assign data_o    = data_oe_o ? rd_data : '0;

  // R1
  read_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && s_vld && !s_wr) |=> rd_valid_q);

  // R5
  bus_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !(s_vld && !s_wr)) |=> !rd_valid_q);

  // R3
  stall_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_ni |=> ($stable(rd_valid_q) && $stable(rd_data)));
endmodule

// File: tb/turnless_sram_tb.sv
module turnless_sram_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cen_n = 1'b0, ce0_n = 1'b1, ce1 = 1'b0, ce2_n = 1'b1;
  logic        rdwr = 1'b1, adv = 1'b0, lin = 1'b1, oe_n = 1'b0, sleep = 1'b0;
  logic [3:0]  be_n = 4'hf;
  logic [5:0]  addr = '0;
  logic [35:0] din = '0;
  logic [35:0] dout;
  logic        doe;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  turnless_sram u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_ni(cen_n), .ce0_ni(ce0_n), .ce1_i(ce1),
    .ce2_ni(ce2_n), .rd_wr_i(rdwr), .adv_i(adv), .burst_lin_i(lin),
    .byte_we_ni(be_n), .addr_i(addr), .oe_ni(oe_n), .sleep_i(sleep),
    .data_i(din), .data_o(dout), .data_oe_o(doe)
  );

  // behavioural reference model
  typedef struct {bit v; bit wr; bit [3:0] ben; int a;} op_t;
  op_t       p1, p2, nw;
  bit [35:0] mmem [64];
  bit        m_act, m_wr, m_lin, exp_rv, ok;
  int        m_base, m_beat, lo;
  bit [35:0] exp_q;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 = '{0, 0, 0, 0}; p2 = '{0, 0, 0, 0};
      m_act = 0; exp_rv = 0; exp_q = '0;
    end else if (!cen_n) begin
      nw = '{0, 0, be_n, 0};
      if (p2.v) begin
        if (p2.wr) begin
          for (int l = 0; l < 4; l++)
            if (!p2.ben[l]) mmem[p2.a][9*l +: 9] = din[9*l +: 9];
        end else exp_q = mmem[p2.a];
      end
      exp_rv = p2.v && !p2.wr;
      if (!adv) begin
        ok = !ce0_n && ce1 && !ce2_n && !sleep;
        m_act = ok;
        if (ok) begin
          m_base = int'(addr); m_beat = 0; m_wr = !rdwr; m_lin = lin;
          nw.v = 1; nw.wr = m_wr; nw.a = m_base;
        end
      end else if (sleep) begin
        m_act = 0;
      end else if (m_act) begin
        m_beat = (m_beat + 1) % 4;
        lo = m_lin ? (m_base + m_beat) % 4 : ((m_base % 4) ^ m_beat);
        nw.v = 1; nw.wr = m_wr; nw.a = (m_base / 4) * 4 + lo;
      end
      p2 = p1; p1 = nw;
    end
  end

  task automatic chk(string req);
    bit          eoe;
    logic [35:0] ed;
    eoe = exp_rv && !oe_n;
    ed  = eoe ? exp_q : 36'd0;
    checks++;
    if (doe !== eoe || dout !== ed) begin
      errors++;
      $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h", req, doe, dout, eoe, ed);
    end
  endtask

  task automatic tick(string req);
    din = {$urandom, $urandom};
    @(posedge clk);
    @(negedge clk);
    chk(req);
  endtask

  task automatic cmd(string req, bit a, bit rw, logic [5:0] ad, logic [3:0] b);
    cen_n = 0; ce0_n = 0; ce1 = 1; ce2_n = 0; sleep = 0;
    adv = a; rdwr = rw; addr = ad; be_n = b;
    tick(req);
  endtask

  task automatic desel(string req);
    cen_n = 0; ce0_n = 1; ce1 = 1; ce2_n = 0; sleep = 0; adv = 0; rdwr = 1;
    tick(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11");                       // R11 reset state, no drive
    rst_n = 1;
    desel("R11");

    // R1 fill whole array, then read back to back
    for (int a = 0; a < 64; a++) cmd("R1", 0, 0, 6'(a), 4'h0);
    for (int a = 0; a < 64; a++) cmd("R1", 0, 1, 6'(a), 4'h0);
    desel("R1"); desel("R1"); desel("R1");

    // R2 same-address write/read and read/write turnarounds
    for (int i = 0; i < 40; i++) begin
      cmd("R2", 0, 0, 6'(i), 4'h0);
      cmd("R2", 0, 1, 6'(i), 4'h0);
      cmd("R2", 0, 1, 6'(i + 1), 4'h0);
      cmd("R2", 0, 0, 6'(i + 1), 4'h0);
    end
    cmd("R2", 0, 1, 6'd1, 4'h0); desel("R2"); desel("R2");

    // R7 partial lane writes
    for (int i = 0; i < 16; i++) begin
      cmd("R7", 0, 0, 6'(i + 20), 4'(i));
      cmd("R7", 0, 1, 6'(i + 20), 4'h0);
    end
    desel("R7"); desel("R7");

    // R6 both orders, every start beat, wraps past four; R8 rd_wr_i toggled on advance
    for (int o = 0; o < 2; o++)
      for (int b = 0; b < 4; b++) begin
        lin = o[0];
        cmd("R8", 0, 0, 6'(36 + b), 4'h0);
        for (int k = 0; k < 5; k++) cmd("R8", 1, k[0], 6'h3f, 4'(k));
        lin = ~o[0];
        cmd("R6", 0, 1, 6'(36 + b), 4'h0);
        for (int k = 0; k < 5; k++) cmd("R6", 1, ~k[0], 6'h00, 4'h0);
        desel("R6"); desel("R6");
      end
    lin = 1;

    // R4 each enable off, and advance with no active burst
    cmd("R4", 0, 1, 6'd5, 4'h0);
    ce0_n = 1; ce1 = 1; ce2_n = 0; adv = 0; rdwr = 0; addr = 6'd5; be_n = 0; tick("R4");
    ce0_n = 0; ce1 = 0; tick("R4");
    ce1 = 1; ce2_n = 1; tick("R4");
    adv = 1; ce2_n = 0; tick("R4");
    tick("R4");
    cmd("R4", 0, 1, 6'd5, 4'h0); desel("R4"); desel("R4");

    // R5 deselect right after reads and writes keeps them alive
    cmd("R5", 0, 1, 6'd7, 4'h0);
    cmd("R5", 0, 0, 6'd8, 4'h0);
    desel("R5"); desel("R5"); desel("R5");
    cmd("R5", 0, 1, 6'd8, 4'h0); desel("R5"); desel("R5");

    // R3 stalls inside a read burst and a write stream
    cmd("R3", 0, 1, 6'd12, 4'h0);
    for (int k = 0; k < 6; k++) begin
      cen_n = 1; adv = 0; rdwr = 0; ce0_n = 1; tick("R3");
      cen_n = 0; ce0_n = 0; adv = 1; tick("R3");
    end
    cmd("R3", 0, 0, 6'd13, 4'h0);
    cen_n = 1; tick("R3"); tick("R3");
    cmd("R3", 0, 1, 6'd13, 4'h0); desel("R3"); desel("R3"); desel("R3");

    // R9 output enable between edges
    cmd("R9", 0, 1, 6'd3, 4'h0);
    cmd("R9", 0, 1, 6'd4, 4'h0);
    desel("R9");
    #1 oe_n = 1; #1 chk("R9");
    oe_n = 0; #1 chk("R9");
    oe_n = 1; desel("R9"); oe_n = 0; #1 chk("R9");
    desel("R9");

    // R10 sleep blocks loads and stops a burst; pending completes
    cmd("R10", 0, 1, 6'd9, 4'h0);
    sleep = 1; adv = 0; rdwr = 0; addr = 6'd9; tick("R10");
    adv = 1; tick("R10");
    sleep = 0; tick("R10");
    cmd("R10", 0, 0, 6'd9, 4'h0);
    sleep = 1; cen_n = 0; adv = 1; tick("R10");
    sleep = 0; tick("R10");
    cmd("R10", 0, 1, 6'd9, 4'h0); cmd("R10", 0, 1, 6'd10, 4'h0);
    desel("R10"); desel("R10");

    // R2 mixed random traffic
    for (int i = 0; i < 400; i++) begin
      cen_n = ($urandom % 8) == 0;
      ce0_n = ($urandom % 10) == 0; ce1 = 1; ce2_n = 0;
      sleep = ($urandom % 20) == 0;
      adv = $urandom; rdwr = $urandom; lin = $urandom;
      addr = 6'($urandom); be_n = 4'($urandom);
      oe_n = ($urandom % 10) == 0;
      tick("R2");
    end
    oe_n = 0;
    desel("R2"); desel("R2"); desel("R2");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule